// File: doc/BRIEF.md
# Cascade Serial Bus Node Port

This block is one node's attachment to a shared serial bus that links several repeater chips into one logical repeater. The bus carries four lines: NRZ data, a framing enable around the data stream, a bit clock and a collision indication. By default the node only listens. It monitors the bus and samples data on each rising edge of the bus clock while the framing enable is high.

When the node has receive activity from one of its own segments and holds the arbitration grant, it takes over the bus. It then drives all four lines and raises an active-high transceiver enable for an external bus buffer. While it drives, it makes the bus clock by dividing its system clock and launches a new data bit on each falling edge of that clock. A local collision flag is forwarded onto the collision line only while the node owns the bus.

Arbitration is a daisy chain. Each node receives an acknowledge from upstream. It passes that acknowledge downstream only when it has no local activity. A node that has local activity and receives the acknowledge wins the bus and blocks the chain below it. All bus inputs are treated as synchronous to the system clock, which oversamples the bus clock.

Top module: `cbus_node`

## Requirements
- R1: After reset, xcvr_en, bus_en_o, bus_clk_o, bus_data_o, bus_col_o, rx_valid, rx_frame and rx_col are all 0.
- R2: ack_out equals ack_in AND NOT loc_act, combinationally in the same cycle.
- R3: xcvr_en and bus_en_o are equal. Both become 1 on the clock edge at which ack_in and loc_act are both 1, and both return to 0 on the first edge at which either of them is 0.
- R4: While driving, bus_clk_o has a period of DIV system clocks (DIV=4 by default). Counting the cycles after the acquiring edge as 0, 1, 2 and so on, bus_clk_o is 0 in cycles whose index mod DIV is below DIV/2 and 1 otherwise.
- R5: While driving, bus_data_o changes only at the acquiring edge or where bus_clk_o falls. The value it takes there is loc_data at that edge. bit_take is 1 in exactly the cycles whose coming edge loads loc_data.
- R6: bus_col_o is loc_col registered while the node keeps ownership across that edge, and 0 otherwise.
- R7: While the node is not taking ownership at an edge, and bus_en_i is 1 and bus_clk_i is 1 after having been 0 in the previous cycle, rx_valid pulses for one cycle after that edge and rx_data holds the bus_data_i value present at that edge. There is no pulse when bus_en_i is 0 or when the node owns the bus after that edge.
- R8: rx_frame and rx_col are bus_en_i and bus_col_i registered, and are forced to 0 at any edge after which the node owns the bus.
- R9: At any edge after which the node does not own the bus, bus_clk_o, bus_data_o and bus_col_o become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_act | input | 1 | Receive activity on one of this node's segments |
| loc_data | input | 1 | Next local NRZ bit to launch |
| loc_col | input | 1 | Local collision flag |
| bit_take | output | 1 | loc_data is consumed at the coming edge |
| ack_in | input | 1 | Acknowledge from upstream in the chain |
| ack_out | output | 1 | Acknowledge passed downstream |
| bus_data_i | input | 1 | Bus data line as seen by the node |
| bus_en_i | input | 1 | Bus framing enable as seen by the node |
| bus_clk_i | input | 1 | Bus clock as seen by the node |
| bus_col_i | input | 1 | Bus collision line as seen by the node |
| bus_data_o | output | 1 | Data driven onto the bus |
| bus_en_o | output | 1 | Framing enable driven onto the bus |
| bus_clk_o | output | 1 | Bus clock driven onto the bus |
| bus_col_o | output | 1 | Collision driven onto the bus |
| xcvr_en | output | 1 | External bus buffer direction: 1 = drive |
| rx_data | output | 1 | Last bit sampled from the bus |
| rx_valid | output | 1 | One-cycle pulse for a new sampled bit |
| rx_frame | output | 1 | Registered bus framing enable while listening |
| rx_col | output | 1 | Registered bus collision while listening |

## Verification
Taking or giving up the bus and sampling a rising bus clock edge can fall on the same system clock edge. This happens when loc_act and ack_in change at the same moment that bus_clk_i goes high with bus_en_i set. The bench sets up both orders. When ownership is taken at the edge where the rise arrives, the expected result is xcvr_en at 1 with no rx_valid pulse and rx_frame and rx_col held at 0. When ownership is released at the edge where the rise arrives, the expected result is an rx_valid pulse carrying the bus data while xcvr_en falls.

// File: rtl/cbus_pkg.sv
package cbus_pkg;

  // Lines this node drives besides the framing enable.
  typedef struct packed {
    logic data;
    logic clk;
    logic col;
  } cbus_lines_t;

  // Phase of the generated bus clock one system cycle later.
  function automatic int next_phase(int ph, int div);
    return (ph >= div - 1) ? 0 : ph + 1;
  endfunction

  // Level of the generated bus clock in a given phase: low first half.
  function automatic logic clk_level(int ph, int div);
    return (ph >= div / 2) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/cbus_arb.sv
module cbus_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_in,
  input  logic loc_act,
  output logic ack_out,
  output logic own_next,
  output logic own_q
);

  // Chain: the grant passes through idle nodes and is held by an active one.
  assign own_next = ack_in & loc_act;
  assign ack_out  = ack_in & ~loc_act;

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= 1'b0;
    else        own_q <= own_next;
  end

  // R3: losing either the grant or the activity ends ownership at the next edge
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_in || !loc_act) |=> !own_q);

  // R2: a node holding activity never forwards the grant
  assert_chain_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loc_act |-> !ack_out);

endmodule

// File: rtl/cbus_tx.sv
module cbus_tx
  import cbus_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        own_next,
  input  logic        own_q,
  input  logic        loc_data,
  input  logic        loc_col,
  output logic        launch,
  output cbus_lines_t drv_q
);

  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int HALF = DIV / 2;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  // Phase restarts on acquisition and wraps every DIV cycles while owning.
  always_comb begin
    if (!own_next)   ph_d = '0;
    else if (!own_q) ph_d = '0;
    else             ph_d = PH_W'(next_phase(int'(ph_q), DIV));
  end

  // A bit is loaded on acquisition and at every falling bus clock edge.
  assign launch = own_next & (~own_q | (ph_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      drv_q <= '0;
    end else begin
      ph_q       <= ph_d;
      drv_q.clk  <= own_next & clk_level(int'(ph_d), DIV);
      drv_q.col  <= own_next & loc_col;
      if (!own_next)   drv_q.data <= 1'b0;
      else if (launch) drv_q.data <= loc_data;
    end
  end

  // R5: an owned data change is always accompanied by a falling bus clock
  assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q && $past(own_q) && !$stable(drv_q.data)) |-> $fell(drv_q.clk));

  // R9: nothing but zeros leaves the node while it is not the owner
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !own_q |-> (!drv_q.clk && !drv_q.data && !drv_q.col));

  generate
    if (HALF > 1) begin : g_hold_chk
      // R4: a high bus clock phase spans more than one system cycle
      assert_clk_high_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q && $rose(drv_q.clk) && own_next) |=> drv_q.clk);
    end
  endgenerate

endmodule

// File: rtl/cbus_rx.sv
module cbus_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic own_next,
  input  logic bus_data_i,
  input  logic bus_en_i,
  input  logic bus_clk_i,
  input  logic bus_col_i,
  output logic rx_data,
  output logic rx_valid,
  output logic rx_frame,
  output logic rx_col
);

  logic prev_clk_q;
  logic rise;
  logic sample;

  assign rise   = bus_clk_i & ~prev_clk_q;
  assign sample = rise & bus_en_i & ~own_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_clk_q <= 1'b0;
      rx_data    <= 1'b0;
      rx_valid   <= 1'b0;
      rx_frame   <= 1'b0;
      rx_col     <= 1'b0;
    end else begin
      prev_clk_q <= bus_clk_i;
      rx_valid   <= sample;
      rx_frame   <= bus_en_i & ~own_next;
      rx_col     <= bus_col_i & ~own_next;
      if (sample) rx_data <= bus_data_i;
    end
  end

  // R7: one rising edge yields exactly one single-cycle pulse
  assert_rx_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: a sampled bit always lies inside a listened frame
  assert_rx_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_frame);

endmodule

// File: rtl/cbus_node.sv
module cbus_node
  import cbus_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_act,
  input  logic loc_data,
  input  logic loc_col,
  output logic bit_take,
  input  logic ack_in,
  output logic ack_out,
  input  logic bus_data_i,
  input  logic bus_en_i,
  input  logic bus_clk_i,
  input  logic bus_col_i,
  output logic bus_data_o,
  output logic bus_en_o,
  output logic bus_clk_o,
  output logic bus_col_o,
  output logic xcvr_en,
  output logic rx_data,
  output logic rx_valid,
  output logic rx_frame,
  output logic rx_col
);

  logic        own_next;
  logic        own_q;
  logic        launch;
  cbus_lines_t drv_q;

  cbus_arb u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_in   (ack_in),
    .loc_act  (loc_act),
    .ack_out  (ack_out),
    .own_next (own_next),
    .own_q    (own_q)
  );

  cbus_tx #(.DIV(DIV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_next (own_next),
    .own_q    (own_q),
    .loc_data (loc_data),
    .loc_col  (loc_col),
    .launch   (launch),
    .drv_q    (drv_q)
  );

  cbus_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_next   (own_next),
    .bus_data_i (bus_data_i),
    .bus_en_i   (bus_en_i),
    .bus_clk_i  (bus_clk_i),
    .bus_col_i  (bus_col_i),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .rx_frame   (rx_frame),
    .rx_col     (rx_col)
  );

  assign bit_take   = launch;
  assign xcvr_en    = own_q;
  assign bus_en_o   = own_q;
  assign bus_clk_o  = drv_q.clk;
  assign bus_data_o = drv_q.data;
  assign bus_col_o  = drv_q.col;

  // R6: collision reaches the bus only from the owning node
  assert_col_owned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_col_o |-> xcvr_en);

  // R3: the buffer turns to drive only after a granted, active cycle
  assert_take_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xcvr_en) |-> $past(ack_in && loc_act));

  // R7: no bit is taken from the bus while this node drives it
  assert_no_self_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !xcvr_en);

endmodule

// File: tb/cbus_node_tb_top.sv
module cbus_node_tb_top;

  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic loc_act, loc_data, loc_col, bit_take;
  logic ack_in, ack_out;
  logic bus_data_i, bus_en_i, bus_clk_i, bus_col_i;
  logic bus_data_o, bus_en_o, bus_clk_o, bus_col_o, xcvr_en;
  logic rx_data, rx_valid, rx_frame, rx_col;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cbus_node #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .loc_act(loc_act), .loc_data(loc_data), .loc_col(loc_col), .bit_take(bit_take),
    .ack_in(ack_in), .ack_out(ack_out),
    .bus_data_i(bus_data_i), .bus_en_i(bus_en_i), .bus_clk_i(bus_clk_i), .bus_col_i(bus_col_i),
    .bus_data_o(bus_data_o), .bus_en_o(bus_en_o), .bus_clk_o(bus_clk_o), .bus_col_o(bus_col_o),
    .xcvr_en(xcvr_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame(rx_frame), .rx_col(rx_col)
  );

  // {ack_in, loc_act, expected ack_out, expected ownership after the edge}
  localparam logic [3:0] ARB_VEC [6] = '{
    4'b0000, 4'b1010, 4'b0100, 4'b1101, 4'b1010, 4'b0100
  };
  localparam logic [4:0]  TX_PAT = 5'b01101;
  localparam logic [16:0] COL_PAT = 17'b0_0110_0001_1100_0100;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    loc_act = 0; loc_data = 0; loc_col = 0; ack_in = 0;
    bus_data_i = 0; bus_en_i = 0; bus_clk_i = 0; bus_col_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    check("R1", "xcvr_en", xcvr_en, 1'b0);
    check("R1", "bus_en_o", bus_en_o, 1'b0);
    check("R1", "bus_clk_o", bus_clk_o, 1'b0);
    check("R1", "bus_data_o", bus_data_o, 1'b0);
    check("R1", "bus_col_o", bus_col_o, 1'b0);
    check("R1", "rx_valid", rx_valid, 1'b0);
    check("R1", "rx_frame", rx_frame, 1'b0);
    check("R1", "rx_col", rx_col, 1'b0);

    // Arbitration table walk: R2 combinational, R3 registered
    for (int i = 0; i < 6; i++) begin
      ack_in  = ARB_VEC[i][3];
      loc_act = ARB_VEC[i][2];
      #1;
      check("R2", "ack_out", ack_out, ARB_VEC[i][1]);
      @(negedge clk);
      check("R3", "xcvr_en", xcvr_en, ARB_VEC[i][0]);
      check("R3", "bus_en_o", bus_en_o, ARB_VEC[i][0]);
    end
    ack_in = 0; loc_act = 0;
    @(negedge clk);

    // Transmit: clock shape, data launch on falling edges, collision forwarding
    ack_in = 1; loc_act = 1; loc_data = TX_PAT[0]; loc_col = COL_PAT[0];
    #1;
    check("R5", "bit_take on acquisition", bit_take, 1'b1);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      check("R3", "xcvr_en while driving", xcvr_en, 1'b1);
      check("R4", "bus_clk_o", bus_clk_o, ((c % DIV) >= DIV / 2));
      check("R5", "bus_data_o", bus_data_o, TX_PAT[c / DIV]);
      check("R6", "bus_col_o", bus_col_o, COL_PAT[c]);
      loc_data = TX_PAT[(c + 1) / DIV];
      loc_col  = COL_PAT[c + 1];
      #1;
      check("R5", "bit_take", bit_take, ((c + 1) % DIV) == 0);
    end

    // Release by activity: all driven lines go quiet, grant flows on
    loc_act = 0; loc_col = 1; loc_data = 1;
    #1;
    check("R2", "ack_out after release", ack_out, 1'b1);
    @(negedge clk);
    check("R3", "xcvr_en after release", xcvr_en, 1'b0);
    check("R9", "bus_clk_o idle", bus_clk_o, 1'b0);
    check("R9", "bus_data_o idle", bus_data_o, 1'b0);
    check("R6", "bus_col_o idle", bus_col_o, 1'b0);

    // Release by loss of grant mid-stream
    loc_act = 1;
    repeat (3) @(negedge clk);
    check("R6", "bus_col_o owned", bus_col_o, 1'b1);
    ack_in = 0;
    #1;
    check("R2", "ack_out no grant", ack_out, 1'b0);
    @(negedge clk);
    check("R3", "xcvr_en grant lost", xcvr_en, 1'b0);
    check("R9", "bus_clk_o grant lost", bus_clk_o, 1'b0);
    loc_act = 0; loc_col = 0; loc_data = 0;
    @(negedge clk);

    // Receive: sampled on rising bus clock inside a frame
    bus_en_i = 1;
    for (int b = 0; b < 3; b++) begin
      logic bit_v;
      bit_v = (b != 1);
      bus_clk_i = 0;
      @(negedge clk);
      bus_clk_i = 1; bus_data_i = bit_v;
      @(negedge clk);
      check("R7", "rx_valid on rise", rx_valid, 1'b1);
      check("R7", "rx_data", rx_data, bit_v);
      check("R8", "rx_frame", rx_frame, 1'b1);
      bus_data_i = ~bit_v;
      @(negedge clk);
      check("R7", "rx_valid single", rx_valid, 1'b0);
      check("R7", "rx_data held", rx_data, bit_v);
    end

    // Rise outside a frame is ignored
    bus_clk_i = 0; bus_en_i = 0; bus_data_i = 0;
    @(negedge clk);
    bus_clk_i = 1;
    @(negedge clk);
    check("R7", "rx_valid without frame", rx_valid, 1'b0);
    check("R8", "rx_frame low", rx_frame, 1'b0);
    check("R7", "rx_data unchanged", rx_data, 1'b1);

    // Collision mirrored while listening
    bus_col_i = 1; bus_en_i = 1; bus_clk_i = 0;
    @(negedge clk);
    check("R8", "rx_col listening", rx_col, 1'b1);

    // Same edge: acquisition and a bus clock rise -> no sample
    bus_clk_i = 1; bus_data_i = 0; ack_in = 1; loc_act = 1;
    @(negedge clk);
    check("R3", "xcvr_en at contested edge", xcvr_en, 1'b1);
    check("R7", "rx_valid at acquisition", rx_valid, 1'b0);
    check("R8", "rx_frame while owning", rx_frame, 1'b0);
    check("R8", "rx_col while owning", rx_col, 1'b0);
    bus_clk_i = 0;
    @(negedge clk);

    // Same edge: release and a bus clock rise -> sample taken
    bus_clk_i = 1; bus_data_i = 0; loc_act = 0;
    @(negedge clk);
    check("R3", "xcvr_en at release edge", xcvr_en, 1'b0);
    check("R7", "rx_valid at release", rx_valid, 1'b1);
    check("R7", "rx_data at release", rx_data, 1'b0);
    check("R8", "rx_col after release", rx_col, 1'b1);

    summary();
    $finish;
  end

endmodule